// File: doc/BRIEF.md
# Serial Flash Block-Erase Command Front End

This block is the slave-side command front end of a serial flash device. It receives bytes on a mode-0 SPI link framed by an active-low chip select. It recognises three commands: set the write-enable latch, return the status byte, and erase one 64 KB block. It owns the status byte, which holds the busy flag, the write-enable latch and an echo of the block-protect configuration.

An accepted erase produces a one-cycle request and an 8-bit block index (address bits 23..16) for the erase engine. A parameterised countdown stands in for the self-timed erase. The busy flag stays set for that whole interval. When the interval ends, the write-enable latch is cleared.

A command acts only when chip select rises, and only if the frame held an exact number of bits. While an erase is in progress, every command except status readback is ignored. The SPI pins are sampled by the system clock, so SCLK must run well below clk/8.

Top module: `flash_erase_front`

## Requirements
- R1: After reset, erase_busy and erase_req are 0, erase_blk is 0x00, and the status byte reads busy=0 and latch=0.
- R2: A frame of exactly 8 bits carrying opcode 0x06 sets the write-enable latch when chip select rises. An 0x06 frame of any other length leaves the latch unchanged.
- R3: A frame of opcode 0xD8 followed by a 24-bit address, sent MSB first, requests an erase if it is accepted. erase_req pulses for one clk cycle, starting on the third clk rising edge after spi_cs_n goes high. erase_blk then holds address bits 23..16 until the next accepted erase.
- R4: An 0xD8 frame whose length is not exactly 32 bits is discarded, for example 31 or 40 bits.
- R5: An 0xD8 frame is discarded when the write-enable latch is 0.
- R6: An 0xD8 frame is discarded when its block is protected. The protected set is chosen by prot_level L and prot_top_bot T:
  - L=0 protects nothing.
  - L=7 protects all 256 blocks.
  - Any other L protects N=2^(L-1) blocks: blocks 0..N-1 when T=1, and blocks 256-N..255 when T=0.
- R7: erase_busy goes high together with erase_req and stays high for exactly ERASE_CYCLES clk cycles. Status bit 0 carries the same flag.
- R8: The write-enable latch is 0 from the cycle in which erase_busy falls.
- R9: While erase_busy is 1, erase and write-enable frames have no effect. A status read during that time returns busy=1.
- R10: Opcode 0x05 returns the status byte MSB first on spi_miso:
  - MISO changes after SCLK falls, and the host samples it on the SCLK rise.
  - The first status bit is valid for the 9th rising edge.
  - The byte repeats for as long as chip select stays low.
  - Bit layout: bit 0 busy, bit 1 write-enable latch, bits 4..2 prot_level, bit 5 prot_top_bot, bits 7..6 zero.
- R11: spi_miso is 0 while chip select is high and outside status readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it also samples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Host-to-device serial data |
| spi_miso | output | 1 | Device-to-host serial data |
| prot_top_bot | input | 1 | Chooses the protected end: 1 low blocks, 0 high blocks |
| prot_level | input | 3 | Size code of the protected range |
| erase_req | output | 1 | One-cycle erase request to the erase engine |
| erase_blk | output | 8 | Index of the 64 KB block to erase |
| erase_busy | output | 1 | Erase interval in progress |

## Verification
A wrong internal state is mostly visible within a few cycles of the next chip-select rise:
- A latch or bit counter left in the wrong state shows up as a missing erase_req, or one that should not be there.
- A countdown off by one moves the falling edge of erase_busy by a single clk cycle.

The bench predicts erase_req, erase_blk and erase_busy for every clk cycle, so both kinds of error are caught in the cycle where they first appear. Latch faults that touch no port right away, such as the latch failing to clear after an erase, are exposed by the next status read or by a later erase that should be rejected.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  localparam logic [7:0] OPC_WREN   = 8'h06;
  localparam logic [7:0] OPC_RDSR   = 8'h05;
  localparam logic [7:0] OPC_BERASE = 8'hD8;
  localparam int BLK_W       = 8;
  localparam int CMD_BITS    = 8;
  localparam int ERASE_BITS  = 32;
  localparam int FRAME_CNT_W = 6;

  // Protected-range test: level 0 none, level 7 all, else 2^(lvl-1) blocks
  // at the low end (tb=1) or at the high end (tb=0).
  function automatic logic blk_protected(input logic tb, input logic [2:0] lvl,
                                         input logic [BLK_W-1:0] blk);
    logic [BLK_W:0] span;
    logic res;
    span = '0;
    if (lvl == 3'd0) begin
      res = 1'b0;
    end else if (lvl == 3'd7) begin
      res = 1'b1;
    end else begin
      span = (BLK_W+1)'(1) << (lvl - 3'd1);
      if (tb) res = ({1'b0, blk} < span);
      else    res = ({1'b0, blk} >= ((BLK_W+1)'(1) << BLK_W) - span);
    end
    return res;
  endfunction

  function automatic logic [7:0] status_byte(input logic busy, input logic wel,
                                             input logic tb, input logic [2:0] lvl);
    return {2'b00, tb, lvl, wel, busy};
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic cs_n_in,
  input  logic mosi_in,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_rise,
  output logic cs_active,
  output logic mosi_s
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] IDLE_VAL = 3'b010; // cs_n idles high

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic sclk_q, cs_q;

  assign raw = {mosi_in, cs_n_in, sclk_in};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= {STAGES{IDLE_VAL[g]}};
      else        ff <= {ff[STAGES-2:0], raw[g]};
    end
    assign synced[g] = ff[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= synced[0];
      cs_q   <= synced[1];
    end
  end

  assign sclk_rise = synced[0] & ~sclk_q;
  assign sclk_fall = ~synced[0] & sclk_q;
  assign cs_rise   = synced[1] & ~cs_q;
  assign cs_active = ~synced[1];
  assign mosi_s    = synced[2];
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import flash_erase_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sclk_rise,
  input  logic                   sclk_fall,
  input  logic                   cs_active,
  input  logic                   mosi,
  input  logic [7:0]             status,
  output logic [7:0]             frame_opc,
  output logic [BLK_W-1:0]       frame_blk,
  output logic [FRAME_CNT_W-1:0] frame_bits,
  output logic                   miso
);
  localparam logic [FRAME_CNT_W-1:0] CNT_MAX = '1;

  logic [23:0] addr_sr;
  logic [2:0]  bit_pos;
  logic        rdsr_q;
  logic [7:0]  out_sr;
  logic [7:0]  opc_next;

  assign opc_next = {addr_sr[6:0], mosi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_sr    <= '0;
      bit_pos    <= '0;
      frame_bits <= '0;
      frame_opc  <= '0;
      rdsr_q     <= 1'b0;
      out_sr     <= '0;
    end else if (!cs_active) begin
      bit_pos    <= '0;
      frame_bits <= '0;
      rdsr_q     <= 1'b0;
      out_sr     <= '0;
    end else begin
      if (sclk_rise) begin
        addr_sr <= {addr_sr[22:0], mosi};
        bit_pos <= bit_pos + 3'd1;
        if (frame_bits != CNT_MAX) frame_bits <= frame_bits + 1'b1;
        if (frame_bits == FRAME_CNT_W'(CMD_BITS - 1)) begin
          frame_opc <= opc_next;
          rdsr_q    <= (opc_next == OPC_RDSR);
        end
      end
      if (sclk_fall) begin
        if (rdsr_q && bit_pos == 3'd0) out_sr <= status;
        else                           out_sr <= {out_sr[6:0], 1'b0};
      end
    end
  end

  assign frame_blk = addr_sr[23:16];
  assign miso      = cs_active & out_sr[7];
endmodule

// File: rtl/erase_ctrl.sv
module erase_ctrl
  import flash_erase_pkg::*;
#(
  parameter int ERASE_CYCLES = 1000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_rise,
  input  logic [7:0]             frame_opc,
  input  logic [BLK_W-1:0]       frame_blk,
  input  logic [FRAME_CNT_W-1:0] frame_bits,
  input  logic                   prot_tb,
  input  logic [2:0]             prot_lvl,
  output logic                   wel,
  output logic                   busy,
  output logic                   erase_req,
  output logic [BLK_W-1:0]       erase_blk,
  output logic                   blk_prot
);
  localparam int CNT_W = (ERASE_CYCLES > 2) ? $clog2(ERASE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ERASE_CYCLES - 1);

  logic [CNT_W-1:0] remain;
  logic wren_frame, erase_frame, erase_ok;

  assign blk_prot    = blk_protected(prot_tb, prot_lvl, frame_blk);
  assign wren_frame  = (frame_opc == OPC_WREN)   && (frame_bits == FRAME_CNT_W'(CMD_BITS));
  assign erase_frame = (frame_opc == OPC_BERASE) && (frame_bits == FRAME_CNT_W'(ERASE_BITS));
  assign erase_ok    = erase_frame && wel && !blk_prot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel       <= 1'b0;
      busy      <= 1'b0;
      erase_req <= 1'b0;
      erase_blk <= '0;
      remain    <= '0;
    end else begin
      erase_req <= 1'b0;
      if (busy) begin
        if (remain == '0) begin
          busy <= 1'b0;
          wel  <= 1'b0;
        end else begin
          remain <= remain - 1'b1;
        end
      end else if (cs_rise) begin
        if (wren_frame) wel <= 1'b1;
        if (erase_ok) begin
          erase_req <= 1'b1;
          busy      <= 1'b1;
          remain    <= CNT_LOAD;
          erase_blk <= frame_blk;
        end
      end
    end
  end
endmodule

// File: rtl/flash_erase_front.sv
module flash_erase_front
  import flash_erase_pkg::*;
#(
  parameter int ERASE_CYCLES = 1000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sclk,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic             spi_miso,
  input  logic             prot_top_bot,
  input  logic [2:0]       prot_level,
  output logic             erase_req,
  output logic [BLK_W-1:0] erase_blk,
  output logic             erase_busy
);
  logic sclk_rise, sclk_fall, cs_rise, cs_active, mosi_s;
  logic [7:0] frame_opc;
  logic [BLK_W-1:0] frame_blk;
  logic [FRAME_CNT_W-1:0] frame_bits;
  logic wel_q, busy_q, blk_prot;
  logic [7:0] status;

  assign status     = status_byte(busy_q, wel_q, prot_top_bot, prot_level);
  assign erase_busy = busy_q;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .sclk_in(spi_sclk), .cs_n_in(spi_cs_n), .mosi_in(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_rise(cs_rise), .cs_active(cs_active), .mosi_s(mosi_s)
  );

  spi_frame_rx u_rx (
    .clk(clk), .rst_n(rst_n),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_active(cs_active),
    .mosi(mosi_s), .status(status),
    .frame_opc(frame_opc), .frame_blk(frame_blk), .frame_bits(frame_bits),
    .miso(spi_miso)
  );

  erase_ctrl #(.ERASE_CYCLES(ERASE_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise),
    .frame_opc(frame_opc), .frame_blk(frame_blk), .frame_bits(frame_bits),
    .prot_tb(prot_top_bot), .prot_lvl(prot_level),
    .wel(wel_q), .busy(busy_q), .erase_req(erase_req),
    .erase_blk(erase_blk), .blk_prot(blk_prot)
  );
endmodule

// File: rtl/flash_erase_front_chk.sv
module flash_erase_front_chk (
  input logic clk,
  input logic rst_n,
  input logic erase_req,
  input logic erase_busy,
  input logic wel_q,
  input logic blk_prot,
  input logic cs_rise
);
  a_r3_req_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !erase_req);
  a_r3_req_after_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> $past(cs_rise));
  a_r5_req_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> $past(wel_q));
  a_r6_req_unprotected: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> !$past(blk_prot));
  a_r7_req_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> erase_busy);
  a_r7_busy_starts_by_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_busy) |-> erase_req);
  a_r8_latch_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(erase_busy) |-> !wel_q);
  a_r9_no_restart_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> !$past(erase_busy));
endmodule

bind flash_erase_front flash_erase_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .erase_req(erase_req), .erase_busy(erase_busy),
  .wel_q(wel_q), .blk_prot(blk_prot), .cs_rise(cs_rise)
);

// File: tb/flash_erase_front_test.sv
module flash_erase_front_test;
  localparam int EC = 600;
  localparam int H  = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso;
  logic prot_top_bot = 1'b0;
  logic [2:0] prot_level = 3'd0;
  logic erase_req, erase_busy;
  logic [7:0] erase_blk;

  flash_erase_front #(.ERASE_CYCLES(EC)) uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .prot_top_bot(prot_top_bot),
    .prot_level(prot_level), .erase_req(erase_req), .erase_blk(erase_blk),
    .erase_busy(erase_busy)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  int m_left = 0;
  bit m_wel = 0, m_req = 0;
  logic [7:0] m_blk = 8'h00;
  bit h1 = 1, h2 = 1, h3 = 1;
  int fb_bits = 0;
  logic [7:0] fb_opc = 8'h00, fb_blk = 8'h00;

  function automatic bit ref_prot(bit tb, int lvl, int blk);
    int n;
    if (lvl == 0) n = 0;
    else if (lvl == 7) n = 256;
    else n = 2 ** (lvl - 1);
    if (tb) return blk < n;
    return blk >= 256 - n;
  endfunction

  function automatic logic [7:0] ref_status();
    logic [7:0] s;
    s = 8'h00;
    s[0] = (m_left > 0);
    s[1] = m_wel;
    s[4:2] = prot_level;
    s[5] = prot_top_bot;
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0; m_wel = 0; m_req = 0; m_blk = 8'h00;
      h1 = 1; h2 = 1; h3 = 1;
    end else begin
      m_req = 0;
      if (m_left > 0) begin
        m_left = m_left - 1;
        if (m_left == 0) m_wel = 0;
      end else if (h2 && !h3) begin
        if (fb_opc == 8'h06 && fb_bits == 8) m_wel = 1;
        if (fb_opc == 8'hD8 && fb_bits == 32 && m_wel &&
            !ref_prot(prot_top_bot, prot_level, fb_blk)) begin
          m_req = 1; m_left = EC; m_blk = fb_blk;
        end
      end
      h3 = h2; h2 = h1; h1 = spi_cs_n;
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3 erase_req", {7'd0, erase_req}, {7'd0, m_req});
      check("R7 erase_busy", {7'd0, erase_busy}, {7'd0, (m_left > 0)});
      check("R3 erase_blk", erase_blk, m_blk);
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [63:0] tx, input int nbits, output logic [63:0] rx);
    rx = '0;
    @(negedge clk);
    spi_cs_n = 1'b0;
    wait_clk(H);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = tx[63-i];
      wait_clk(H);
      rx = {rx[62:0], spi_miso};
      spi_sclk = 1'b1;
      wait_clk(H);
      spi_sclk = 1'b0;
    end
    wait_clk(H);
    fb_bits = nbits;
    fb_opc  = tx[63:56];
    fb_blk  = tx[55:48];
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    wait_clk(8);
  endtask

  task automatic send(input logic [7:0] opc, input logic [23:0] addr, input int nbits);
    logic [63:0] rx;
    xfer({opc, addr, 32'h0}, nbits, rx);
  endtask

  task automatic read_status(string tag, int nbytes);
    logic [63:0] rx;
    logic [7:0] exp;
    xfer({8'h05, 56'h0}, 8 + 8 * nbytes, rx);
    exp = ref_status();
    for (int b = 0; b < nbytes; b++)
      check(tag, 8'(rx >> (8 * (nbytes - 1 - b))), exp);
  endtask

  initial begin
    wait_clk(5);
    check("R1 busy at reset", {7'd0, erase_busy}, 8'd0);
    check("R1 req at reset", {7'd0, erase_req}, 8'd0);
    check("R11 miso idle", {7'd0, spi_miso}, 8'd0);
    rst_n = 1'b1;
    wait_clk(4);
    read_status("R1 status after reset", 1);
    check("R11 miso after frame", {7'd0, spi_miso}, 8'd0);

    send(8'hD8, 24'h12_3456, 32);           // no latch: ignored (R5)
    read_status("R5 status after rejected erase", 1);
    send(8'h06, 24'h0, 9);                  // wrong length: ignored (R2)
    read_status("R2 nine-bit write enable ignored", 1);
    send(8'h06, 24'h0, 8);                  // sets latch (R2)
    read_status("R2 latch set", 1);
    send(8'hD8, 24'h12_3456, 31);           // R4 short frame
    send(8'hD8, 24'h12_3456, 40);           // R4 long frame
    read_status("R4 latch kept, no busy", 2);

    prot_top_bot = 1'b0; prot_level = 3'd2; // blocks FE,FF protected
    wait_clk(4);
    read_status("R10 protect bits in status", 1);
    send(8'hD8, 24'hFF_0000, 32);           // R6 rejected
    send(8'hD8, 24'hFE_1234, 32);           // R6 rejected
    read_status("R6 protected block not erased", 1);
    send(8'hD8, 24'hFD_0000, 32);           // R3 accepted
    read_status("R9 status read while busy", 2);
    send(8'hD8, 24'h10_0000, 32);           // R9 ignored while busy
    wait (m_left == 0);
    wait_clk(4);
    read_status("R8 latch cleared after erase", 1);
    send(8'hD8, 24'h10_0000, 32);           // R8 latch gone: rejected
    read_status("R8 no erase after clear", 1);

    prot_top_bot = 1'b1; prot_level = 3'd1; // block 00 protected
    send(8'h06, 24'h0, 8);
    send(8'hD8, 24'h00_FFFF, 32);           // R6 rejected
    send(8'hD8, 24'h01_0000, 32);           // R3 accepted
    wait (m_left == 0);
    wait_clk(4);

    prot_level = 3'd7;                      // all protected
    send(8'h06, 24'h0, 8);
    send(8'hD8, 24'h80_0000, 32);           // R6 rejected
    read_status("R6 all protected", 1);
    prot_level = 3'd0;
    send(8'hD8, 24'hFF_0000, 32);           // R3 accepted, none protected
    read_status("R7 busy during erase", 1);
    wait (m_left == 0);
    wait_clk(4);
    read_status("R8 final status", 1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    n_cmp++;
    n_bad++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule